// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block watches sixteen asynchronous input pins and turns them into level-sensitive interrupts. Each pin is brought into the clock domain by a two-flop synchronizer. It then goes through its own debounce filter, which counts ticks of an external millisecond strobe. A new level is accepted only once it has stayed unchanged for the programmed number of ticks. Software reads the filtered levels through a data-enable mask. It chooses the active level of each channel, enables interrupts, and clears status with write-one-to-clear. Everything goes through a small word-addressed register file with single-cycle writes and combinational reads.

A channel does nothing until software writes a one to its bit of the start register. That write arms the channel: its filtered level is loaded from the synchronized pin, and detection begins. Each channel runs a small state machine with three states:

- `LN_OFF`: unarmed since reset.
- `LN_STEADY`: the filtered level agrees with the pin.
- `LN_SETTLE`: a differing level is being timed.

The transitions are:

- A start pulse takes any state to `LN_STEADY`.
- `LN_STEADY` goes to `LN_SETTLE` when the synchronized pin differs from the filtered level and the debounce count is non-zero.
- `LN_SETTLE` returns to `LN_STEADY` in two cases: when the pin falls back (the change is rejected), or when the count of ticks is reached (the change is accepted).

With a count of zero, `LN_STEADY` copies a new level directly.

Top module: `xint_debounce_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: All channels are input-only. A write to the data register (offset 0x00) has no effect on any register or output.
- R3: Reading offset 0x00 returns, in bit n, channel n's filtered level ANDed with bit n of the data-enable mask at offset 0x04 (read/write).
- R4: A channel that has not been armed since reset reads as level 0 and never sets its raw status, whatever its pin does.
- R5: Writing 1 to bit n at offset 0x28 arms channel n with a one-cycle pulse, and its filtered level is loaded from the synchronized pin. Writing 0 has no effect. Offset 0x28 always reads zero.
- R6: Polarity at offset 0x14 selects the active level: bit n = 1 means active high, 0 means active low. Raw status at offset 0x1C bit n sets on the edge after an armed channel's filtered level equals its polarity bit.
- R7: Masked status at offset 0x20 equals raw status ANDed with interrupt enable at offset 0x18. `irq_out` is the OR of the masked status bits.
- R8: Writing 1 to bit n at offset 0x24 clears raw bit n at that edge. If the channel is still active, the bit sets again one cycle later. Writing 0 leaves raw status unchanged. Offset 0x24 reads zero.
- R9: Channel n's control register at offset 0x40 + 4n reads back all 32 written bits. Bits 11:0 are the debounce count in ticks. With a count of 0, a pin change appears in the data register on the third clock edge after it.
- R10: With a non-zero count N, a new level is accepted only after N `ms_tick` pulses during which the synchronized pin stays at the new value. A pulse shorter than that is rejected, and with no ticks the level never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pin_in | input | 16 | Asynchronous input pins, bit n is channel n |
| ms_tick | input | 1 | One-cycle millisecond strobe for debounce timing |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is the edge of the debounce window. The bench must show that a level held for fewer than N ticks is thrown away while one held for N ticks is taken. To get there, it generates ticks at a fixed ten-cycle spacing and counts the clock cycles after a pin flip. Channel 3 is then sampled at a point that cannot yet contain N ticks, and again at one that must. For the glitch case, the pin flips back inside the window. A second hard spot is the single cycle in which a write-one-to-clear wins over a still-active level: the bench reads raw status at the falling edge straight after the clearing write, and again one cycle later.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic [1:0] {
        LN_OFF    = 2'd0,
        LN_STEADY = 2'd1,
        LN_SETTLE = 2'd2
    } lane_state_e;

    localparam int OFS_DATA  = 'h00;
    localparam int OFS_DMASK = 'h04;
    localparam int OFS_POL   = 'h14;
    localparam int OFS_IE    = 'h18;
    localparam int OFS_RAW   = 'h1C;
    localparam int OFS_MIS   = 'h20;
    localparam int OFS_CLR   = 'h24;
    localparam int OFS_TRIG  = 'h28;
    localparam int OFS_CTRL  = 'h40;

endpackage

// File: rtl/xint_sync2.sv
module xint_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/xint_lane.sv
module xint_lane
    import xint_pkg::*;
#(
    parameter int DBW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_async,
    input  logic           ms_tick,
    input  logic           arm,
    input  logic [DBW-1:0] limit,
    input  logic           polarity,
    input  logic           clr,
    output logic           level,
    output logic           raw
);
    logic           pin_s;
    lane_state_e    st_q, st_d;
    logic [DBW-1:0] cnt_q;
    logic           differ;
    logic           no_filter;
    logic           tick_done;
    logic           hit;

    xint_sync2 #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_async),
        .q     (pin_s)
    );

    assign differ    = (pin_s != level);
    assign no_filter = (limit == '0);
    assign tick_done = no_filter || (ms_tick && (cnt_q >= DBW'(limit - 1'b1)));
    assign hit       = (st_q != LN_OFF) && (level == polarity);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_OFF: begin
                if (arm) st_d = LN_STEADY;
            end
            LN_STEADY: begin
                if (arm)                          st_d = LN_STEADY;
                else if (differ && !no_filter)    st_d = LN_SETTLE;
            end
            LN_SETTLE: begin
                if (arm || !differ || tick_done)  st_d = LN_STEADY;
            end
            default: st_d = LN_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_OFF;
        else        st_q <= st_d;
    end

    // outputs: filtered level, tick counter, raw status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt_q <= '0;
            raw   <= 1'b0;
        end else begin
            if (arm) begin
                level <= pin_s;
                cnt_q <= '0;
            end else if (st_q == LN_STEADY) begin
                cnt_q <= '0;
                if (differ && no_filter) level <= pin_s;
            end else if (st_q == LN_SETTLE) begin
                if (!differ) begin
                    cnt_q <= '0;
                end else if (tick_done) begin
                    level <= pin_s;
                    cnt_q <= '0;
                end else if (ms_tick) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            raw <= clr ? 1'b0 : (raw | hit);
        end
    end

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_OFF && !arm) |=> (!raw && $stable(level)));

    // R10
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_SETTLE && !ms_tick && !arm && !no_filter) |=> $stable(level));

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !raw);
endmodule

// File: rtl/xint_debounce_ctrl.sv
module xint_debounce_ctrl
    import xint_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DBW    = 12,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              ms_tick,
    output logic              irq_out
);
    logic [NUM_CH-1:0] dmask_q, pol_q, ie_q;
    logic [NUM_CH-1:0] level, raw, mis;
    logic [NUM_CH-1:0] clr_pulse, arm_pulse;
    logic [DW-1:0]     ctrl_q [NUM_CH];

    logic sel_dmask, sel_pol, sel_ie, sel_clr, sel_trig;

    assign sel_dmask = (reg_addr == AW'(OFS_DMASK));
    assign sel_pol   = (reg_addr == AW'(OFS_POL));
    assign sel_ie    = (reg_addr == AW'(OFS_IE));
    assign sel_clr   = (reg_addr == AW'(OFS_CLR));
    assign sel_trig  = (reg_addr == AW'(OFS_TRIG));

    assign clr_pulse = (reg_we && sel_clr)  ? reg_wdata[NUM_CH-1:0] : '0;
    assign arm_pulse = (reg_we && sel_trig) ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dmask_q <= '0;
            pol_q   <= '0;
            ie_q    <= '0;
        end else if (reg_we) begin
            if (sel_dmask) dmask_q <= reg_wdata[NUM_CH-1:0];
            if (sel_pol)   pol_q   <= reg_wdata[NUM_CH-1:0];
            if (sel_ie)    ie_q    <= reg_wdata[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[g] <= '0;
            else if (reg_we && reg_addr == AW'(OFS_CTRL + 4*g))
                ctrl_q[g] <= reg_wdata;
        end

        xint_lane #(.DBW(DBW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[g]),
            .ms_tick   (ms_tick),
            .arm       (arm_pulse[g]),
            .limit     (ctrl_q[g][DBW-1:0]),
            .polarity  (pol_q[g]),
            .clr       (clr_pulse[g]),
            .level     (level[g]),
            .raw       (raw[g])
        );
    end

    assign mis     = raw & ie_q;
    assign irq_out = |mis;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_DATA))  reg_rdata = DW'(level & dmask_q);
        if (sel_dmask)                  reg_rdata = DW'(dmask_q);
        if (sel_pol)                    reg_rdata = DW'(pol_q);
        if (sel_ie)                     reg_rdata = DW'(ie_q);
        if (reg_addr == AW'(OFS_RAW))   reg_rdata = DW'(raw);
        if (reg_addr == AW'(OFS_MIS))   reg_rdata = DW'(mis);
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == AW'(OFS_CTRL + 4*i)) reg_rdata = ctrl_q[i];
        end
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq_out);

    // R2
    data_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(OFS_DATA)) |=>
            ($stable(dmask_q) && $stable(pol_q) && $stable(ie_q)));

    // R5
    trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_trig |-> (reg_rdata == '0));
endmodule

// File: tb/xint_debounce_ctrl_test.sv
module xint_debounce_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic        ms_tick = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit tick_en = 1'b0;
    int tcnt = 0;

    always #5 clk = ~clk;

    xint_debounce_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .ms_tick(ms_tick), .irq_out(irq_out)
    );

    always @(negedge clk) begin
        tcnt    <= (tcnt == 9) ? 0 : tcnt + 1;
        ms_tick <= tick_en && (tcnt == 9);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] pats [6];
        pats[0] = 16'hA5C3; pats[1] = 16'h0000; pats[2] = 16'hFFFF;
        pats[3] = 16'h1234; pats[4] = 16'h8001; pats[5] = 16'h5A5A;

        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1: every register reads zero after reset
        for (int a = 0; a < 'h80; a += 4) begin
            rd(8'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        // R4: unarmed channels ignore pins
        pin_in = 16'hA5C3;
        wr(8'h04, 32'hFFFF);
        wr(8'h18, 32'hFFFF);
        cyc(6);
        rd(8'h00, v); chk("R4 unarmed data", v, 32'h0);
        rd(8'h1C, v); chk("R4 unarmed raw", v, 32'h0);

        // R5: writing zero arms nothing; writing ones arms all, reads back zero
        wr(8'h28, 32'h0);
        cyc(3);
        rd(8'h00, v); chk("R5 zero trig write", v, 32'h0);
        wr(8'h28, 32'hFFFF);
        rd(8'h28, v); chk("R5 trig reads zero", v, 32'h0);
        cyc(2);
        rd(8'h00, v); chk("R5 armed data", v, 32'hA5C3);

        // R3: data gated by mask, swept over pin and mask patterns
        for (int p = 0; p < 6; p++) begin
            pin_in = pats[p];
            cyc(5);
            for (int m = 0; m < 6; m++) begin
                wr(8'h04, {16'h0, pats[m]});
                rd(8'h00, v);
                chk("R3 masked data", v, {16'h0, pats[p] & pats[m]});
            end
        end
        wr(8'h04, 32'hFFFF);

        // R2: data register write is ignored
        pin_in = 16'h3C3C;
        cyc(5);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 data after write", v, 32'h3C3C);
        rd(8'h04, v); chk("R2 mask untouched", v, 32'hFFFF);
        rd(8'h14, v); chk("R2 polarity untouched", v, 32'h0);

        // R6 + R7: polarity sweep with status and enable
        for (int p = 0; p < 6; p++) begin
            pin_in = pats[p];
            cyc(5);
            for (int q = 0; q < 6; q++) begin
                wr(8'h14, {16'h0, pats[q]});
                wr(8'h24, 32'hFFFF);
                cyc(2);
                rd(8'h1C, v);
                chk("R6 raw vs polarity", v, {16'h0, ~(pats[p] ^ pats[q])});
                wr(8'h18, {16'h0, pats[(q + 3) % 6]});
                rd(8'h20, v);
                chk("R7 masked status", v, {16'h0, ~(pats[p] ^ pats[q]) & pats[(q + 3) % 6]});
                chk("R7 irq", {31'b0, irq_out}, {31'b0, |(~(pats[p] ^ pats[q]) & pats[(q + 3) % 6])});
            end
        end
        wr(8'h18, 32'h0);
        cyc(1);
        chk("R7 irq with enable zero", {31'b0, irq_out}, 32'h0);

        // R8: clear priority and re-set
        pin_in = 16'h00F0;
        wr(8'h14, 32'h00F0);
        cyc(5);
        rd(8'h1C, v); chk("R8 all active", v, 32'hFFFF);
        wr(8'h24, 32'h0001);
        rd(8'h1C, v); chk("R8 clear same cycle", v, 32'hFFFE);
        cyc(1);
        rd(8'h1C, v); chk("R8 re-set next cycle", v, 32'hFFFF);
        wr(8'h24, 32'h0);
        rd(8'h1C, v); chk("R8 zero clear no effect", v, 32'hFFFF);
        rd(8'h24, v); chk("R8 clear reads zero", v, 32'h0);
        wr(8'h14, 32'h00F1);
        wr(8'h24, 32'h0001);
        cyc(2);
        rd(8'h1C, v); chk("R8 inactive stays clear", v, 32'hFFFE);

        // R9: control register readback
        for (int i = 0; i < 16; i++)
            wr(8'('h40 + 4*i), 32'h9000_0ABC ^ (i * 32'h0101_0101));
        for (int i = 0; i < 16; i++) begin
            rd(8'('h40 + 4*i), v);
            chk("R9 ctrl readback", v, 32'h9000_0ABC ^ (i * 32'h0101_0101));
        end
        for (int i = 0; i < 16; i++)
            wr(8'('h40 + 4*i), 32'hF000_0000);
        // R9: zero count -> three-edge latency
        pin_in = 16'h0000;
        cyc(5);
        @(negedge clk);
        pin_in = 16'h0180;
        cyc(2);
        rd(8'h00, v); chk("R9 before third edge", v, 32'h0);
        cyc(1);
        rd(8'h00, v); chk("R9 at third edge", v, 32'h0180);

        // R10: debounce on channel 3 with count 4
        wr(8'h4C, 32'h0000_0004);
        pin_in = 16'h0000;
        cyc(5);
        pin_in = 16'h0008;
        cyc(100);
        rd(8'h00, v); chk("R10 no ticks holds", v, 32'h0);
        tick_en = 1'b1;
        cyc(25);
        rd(8'h00, v); chk("R10 before window", v, 32'h0);
        cyc(40);
        rd(8'h00, v); chk("R10 accepted", v, 32'h0008);
        pin_in = 16'h0000;
        cyc(25);
        rd(8'h00, v); chk("R10 glitch low pending", v, 32'h0008);
        pin_in = 16'h0008;
        cyc(80);
        rd(8'h00, v); chk("R10 glitch rejected", v, 32'h0008);
        pin_in = 16'h0018;
        cyc(5);
        rd(8'h00, v); chk("R10 unfiltered neighbour", v, 32'h0018);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule